// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counts of a CAN protocol controller and derives the node's error state from them. A bit-level protocol engine drives it with one-cycle event strobes. These strobes report an error and its kind, the start and end of an error or overload flag, the first bit of the error delimiter, and successful transmission or reception. The engine also passes the sampled bus level together with a one-cycle bit-time strobe, so the block can score runs of dominant bits after a flag.

Penalties that arise during an error frame build up in a pending accumulator. They reach the visible counts only on the delimiter strobe. The rule that applies to each error is chosen from the node's state at the time the error is reported. All pins are plain control and status levels or strobes. No data flows through the block, so there is no valid/ready stage and no back-pressure: every strobe is taken in the cycle it is high. The role input `is_tx_i` must stay stable from the error report to the delimiter.

The error-kind code on `err_kind_i` is: 0 bit error, 1 stuff error, 2 CRC error, 3 form error, 4 acknowledgement error. Dominant is `bus_dom_i` = 1.

Top module: `can_fault_counters`

## Requirements
- R1: After reset the transmit count and the receive count are 0, the receive-passive flag is clear and only `err_active_o` is high.
- R2: Error penalties leave the visible counts unchanged until the cycle after `delim_i`, and then all of them appear together. The counts change only in the cycle after `delim_i`, `tx_ok_i`, `rx_ok_i` or `cnt_clear_i`.
- R3: A receiver (`is_tx_i` = 0) that reports an error which is not a bit error during its own flag adds 1 to the receive count.
- R4: A transmitter that reports an error adds 8 to the transmit count, with two exceptions. A stuff error (kind 1) with `err_arb_stuff_i` high adds nothing. An acknowledgement error (kind 4) reported while error-passive adds nothing, unless a dominant bit is sampled between `flag_start_i` and `flag_done_i`, in which case it adds 8.
- R5: A bit error (kind 0) reported with `err_in_flag_i` high adds 8 to the count of the node's role.
- R6: A receiver that samples dominant on the first bit tick after `flag_done_i` adds 8 to the receive count.
- R7: Dominant-run penalties go to the count of the node's role. After an active or overload flag starts (`flag_passive_i` = 0), 14 consecutive dominant ticks add 8, and each further 8 consecutive dominant ticks add 8 more. After a passive flag ends, each run of 8 consecutive dominant ticks adds 8. A recessive tick ends the run.
- R8: `tx_ok_i` lowers the transmit count by 1, and a count of 0 stays 0.
- R9: When the receive-passive flag is clear, `rx_ok_i` lowers the receive count by 1, and a count of 0 stays 0. When the flag is set, `rx_ok_i` clears it and loads the receive count with 127.
- R10: A committed receive increment that would pass 127 sets the receive-passive flag and holds the count at 127. While the flag is set, receive penalties leave the count unchanged.
- R11: Exactly one of `err_active_o`, `err_passive_o` and `bus_off_o` is high. The node is passive when the transmit count is at least 128 or the receive-passive flag is set.
- R12: A commit that brings the transmit count to 256 or more enters bus-off, with the transmit count held at 255. In bus-off all events are ignored. `cnt_clear_i` zeroes both counts, clears the flag and leaves bus-off.
- R13: A bit error reported with `err_in_ifs_i` high changes no count. Instead, `ovl_req_o` pulses high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clear_i | input | 1 | Strobe: zero both counts and leave bus-off |
| is_tx_i | input | 1 | Role: 1 transmitter, 0 receiver |
| err_det_i | input | 1 | Strobe: error detected |
| err_kind_i | input | 3 | Error kind code (see R4, R5) |
| err_in_flag_i | input | 1 | Error arose while sending an active error or overload flag |
| err_arb_stuff_i | input | 1 | Stuff error on a recessive stuff bit in arbitration |
| err_in_ifs_i | input | 1 | Error arose during intermission |
| flag_start_i | input | 1 | Strobe: error or overload flag begins |
| flag_passive_i | input | 1 | Qualifies `flag_start_i`: passive flag |
| flag_done_i | input | 1 | Strobe: own flag completed |
| bit_tick_i | input | 1 | Strobe: one bit time sampled |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant |
| delim_i | input | 1 | Strobe: first bit of the error delimiter, commit |
| tx_ok_i | input | 1 | Strobe: frame sent without error |
| rx_ok_i | input | 1 | Strobe: frame received without error |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 7 | Receive error count |
| rec_pass_o | output | 1 | Receive count is beyond 127 |
| err_active_o | output | 1 | Node is error-active |
| err_passive_o | output | 1 | Node is error-passive |
| bus_off_o | output | 1 | Node is bus-off |
| ovl_req_o | output | 1 | One-cycle overload frame request |

## Verification
The conditions that need the most setup are the acknowledgement exception, which only applies while the node is already passive, and the transition into bus-off. Both require the transmit count to be pushed past 128 and then toward 256. The stimulus does this by repeating full transmitter error frames until a bench-side count model reaches each threshold. It then tests the acknowledgement error once with a silent passive flag and once with a dominant bit inside the flag. The second 8-bit penalty of a dominant run needs 22 unbroken dominant ticks after the flag start. The stimulus drives exactly that run, so both penalty points fall inside a single error frame.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [2:0] {
    ERR_BIT   = 3'd0,
    ERR_STUFF = 3'd1,
    ERR_CRC   = 3'd2,
    ERR_FORM  = 3'd3,
    ERR_ACK   = 3'd4
  } err_kind_e;

  typedef enum logic [1:0] {
    NODE_ACTIVE  = 2'd0,
    NODE_PASSIVE = 2'd1,
    NODE_BUSOFF  = 2'd2
  } node_state_e;

endpackage

// File: rtl/cfc_dom_run.sv
// Tracks consecutive dominant bit times after a flag and emits a penalty
// strobe each time a run threshold is reached.
module cfc_dom_run #(
  parameter int FIRST_ACT = 14,
  parameter int FIRST_PAS = 8,
  parameter int REPEAT    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic act_start_i,
  input  logic pas_start_i,
  input  logic flag_done_i,
  input  logic tick_i,
  input  logic dom_i,
  output logic pen_o
);

  localparam int MAXR = (FIRST_ACT > FIRST_PAS) ?
                        ((FIRST_ACT > REPEAT) ? FIRST_ACT : REPEAT) :
                        ((FIRST_PAS > REPEAT) ? FIRST_PAS : REPEAT);
  localparam int CW   = $clog2(MAXR + 1);

  logic          running;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_nxt;
  logic          hit;

  assign cnt_nxt = cnt + CW'(1);
  assign hit     = running && tick_i && dom_i && (cnt_nxt == thr);
  assign pen_o   = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      thr     <= CW'(FIRST_ACT);
    end else if (stop_i) begin
      running <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else if (act_start_i) begin
      running <= 1'b1;
      armed   <= 1'b0;
      cnt     <= '0;
      thr     <= CW'(FIRST_ACT);
    end else if (pas_start_i) begin
      running <= 1'b0;
      armed   <= 1'b1;
      cnt     <= '0;
    end else if (flag_done_i && armed) begin
      armed   <= 1'b0;
      running <= 1'b1;
      cnt     <= '0;
      thr     <= CW'(FIRST_PAS);
    end else if (running && tick_i) begin
      if (!dom_i) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (hit) begin
        cnt <= '0;
        thr <= CW'(REPEAT);
      end else begin
        cnt <= cnt_nxt;
      end
    end
  end

endmodule

// File: rtl/cfc_pending.sv
// Classifies error events and accumulates the weighted penalties of one
// error frame until the delimiter commits them.
module cfc_pending
  import cfc_pkg::*;
#(
  parameter int PW  = 10,
  parameter int PEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          err_det_i,
  input  err_kind_e     err_kind_i,
  input  logic          in_flag_i,
  input  logic          arb_stuff_i,
  input  logic          in_ifs_i,
  input  logic          is_tx_i,
  input  logic          passive_i,
  input  logic          flag_start_i,
  input  logic          flag_done_i,
  input  logic          tick_i,
  input  logic          dom_i,
  input  logic          run_pen_i,
  output logic [PW-1:0] pend_tec_o,
  output logic [PW-1:0] pend_rec_o,
  output logic          ovl_req_o
);

  logic          ev, is_bit, ev_ifs, ev_flag, ev_plain;
  logic          exc_arb, exc_ack;
  logic          ack_hold, flag_win, rx_watch, after_flag;
  logic          ack_dom, after_dom, pen_en;
  logic [2:0]    n_tec, n_rec;
  logic [PW-1:0] tec_add, rec_add;
  logic [PW-1:0] pend_tec, pend_rec;

  function automatic logic [PW-1:0] sat_add(input logic [PW-1:0] a,
                                            input logic [PW-1:0] b);
    logic [PW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PW] ? '1 : s[PW-1:0];
  endfunction

  assign ev       = en_i && err_det_i;
  assign is_bit   = (err_kind_i == ERR_BIT);
  assign ev_ifs   = ev && in_ifs_i && is_bit;
  assign ev_flag  = ev && !ev_ifs && in_flag_i && is_bit;
  assign ev_plain = ev && !ev_ifs && !ev_flag;
  assign exc_arb  = (err_kind_i == ERR_STUFF) && arb_stuff_i;
  assign exc_ack  = (err_kind_i == ERR_ACK) && passive_i;

  assign ack_dom   = en_i && ack_hold && flag_win && tick_i && dom_i;
  assign after_dom = en_i && after_flag && tick_i && dom_i;
  assign pen_en    = en_i && run_pen_i;

  always_comb begin
    n_tec = {2'b0, ev_flag && is_tx_i}
          + {2'b0, ev_plain && is_tx_i && !exc_arb && !exc_ack}
          + {2'b0, ack_dom}
          + {2'b0, pen_en && is_tx_i};
    n_rec = {2'b0, ev_flag && !is_tx_i}
          + {2'b0, after_dom}
          + {2'b0, pen_en && !is_tx_i};
    tec_add = PW'(n_tec) * PW'(PEN);
    rec_add = PW'(n_rec) * PW'(PEN) + PW'(ev_plain && !is_tx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tec   <= '0;
      pend_rec   <= '0;
      ack_hold   <= 1'b0;
      flag_win   <= 1'b0;
      rx_watch   <= 1'b0;
      after_flag <= 1'b0;
    end else if (clr_i) begin
      pend_tec   <= '0;
      pend_rec   <= '0;
      ack_hold   <= 1'b0;
      flag_win   <= 1'b0;
      rx_watch   <= 1'b0;
      after_flag <= 1'b0;
    end else if (en_i) begin
      pend_tec <= sat_add(pend_tec, tec_add);
      pend_rec <= sat_add(pend_rec, rec_add);
      if (ev_plain && is_tx_i && exc_ack && !exc_arb) ack_hold <= 1'b1;
      else if (ack_dom)                               ack_hold <= 1'b0;
      if (flag_start_i)     flag_win <= 1'b1;
      else if (flag_done_i) flag_win <= 1'b0;
      if (ev && !ev_ifs && !is_tx_i) rx_watch <= 1'b1;
      else if (flag_done_i)          rx_watch <= 1'b0;
      if (flag_done_i && rx_watch) after_flag <= 1'b1;
      else if (tick_i)             after_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_req_o <= 1'b0;
    else        ovl_req_o <= ev_ifs;
  end

  assign pend_tec_o = pend_tec;
  assign pend_rec_o = pend_rec;

endmodule

// File: rtl/cfc_counters.sv
// Visible transmit/receive counts, receive-passive flag, bus-off latch
// and the derived node state.
module cfc_counters
  import cfc_pkg::*;
#(
  parameter int TEC_W     = 8,
  parameter int REC_W     = 7,
  parameter int PW        = 10,
  parameter int RX_RELOAD = 127,
  parameter int PASS_TEC  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             commit_i,
  input  logic [PW-1:0]    pend_tec_i,
  input  logic [PW-1:0]    pend_rec_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             rec_pass_o,
  output node_state_e      state_o
);

  localparam int TEC_MAX = (1 << TEC_W) - 1;
  localparam int REC_MAX = (1 << REC_W) - 1;
  localparam int SW      = PW + 1;

  logic [TEC_W-1:0] tec;
  logic [REC_W-1:0] rec;
  logic             pass;
  logic             boff;
  logic [SW-1:0]    tec_sum, rec_sum;

  assign tec_sum = SW'(tec) + SW'(pend_tec_i);
  assign rec_sum = SW'(rec) + SW'(pend_rec_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec  <= '0;
      rec  <= '0;
      pass <= 1'b0;
      boff <= 1'b0;
    end else if (clr_i) begin
      tec  <= '0;
      rec  <= '0;
      pass <= 1'b0;
      boff <= 1'b0;
    end else if (!boff) begin
      if (commit_i) begin
        if (tec_sum > SW'(TEC_MAX)) begin
          tec  <= TEC_W'(TEC_MAX);
          boff <= 1'b1;
        end else begin
          tec <= tec_sum[TEC_W-1:0];
        end
        if (!pass) begin
          if (rec_sum > SW'(REC_MAX)) begin
            rec  <= REC_W'(REC_MAX);
            pass <= 1'b1;
          end else begin
            rec <= rec_sum[REC_W-1:0];
          end
        end
      end else begin
        if (tx_ok_i && tec != '0) tec <= tec - TEC_W'(1);
        if (rx_ok_i) begin
          if (pass) begin
            pass <= 1'b0;
            rec  <= REC_W'(RX_RELOAD);
          end else if (rec != '0) begin
            rec <= rec - REC_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    if (boff)                                 state_o = NODE_BUSOFF;
    else if (pass || tec >= TEC_W'(PASS_TEC)) state_o = NODE_PASSIVE;
    else                                      state_o = NODE_ACTIVE;
  end

  assign tec_o      = tec;
  assign rec_o      = rec;
  assign rec_pass_o = pass;

endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
  import cfc_pkg::*;
#(
  parameter int TEC_W     = 8,
  parameter int REC_W     = 7,
  parameter int PENALTY   = 8,
  parameter int ACT_RUN   = 14,
  parameter int PAS_RUN   = 8,
  parameter int REP_RUN   = 8,
  parameter int RX_RELOAD = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clear_i,
  input  logic             is_tx_i,
  input  logic             err_det_i,
  input  logic [2:0]       err_kind_i,
  input  logic             err_in_flag_i,
  input  logic             err_arb_stuff_i,
  input  logic             err_in_ifs_i,
  input  logic             flag_start_i,
  input  logic             flag_passive_i,
  input  logic             flag_done_i,
  input  logic             bit_tick_i,
  input  logic             bus_dom_i,
  input  logic             delim_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             rec_pass_o,
  output logic             err_active_o,
  output logic             err_passive_o,
  output logic             bus_off_o,
  output logic             ovl_req_o
);

  localparam int PW       = TEC_W + 2;
  localparam int PASS_TEC = 1 << (TEC_W - 1);

  node_state_e   state;
  logic          en;
  logic          run_pen;
  logic [PW-1:0] pend_tec, pend_rec;

  assign en            = (state != NODE_BUSOFF);
  assign err_active_o  = (state == NODE_ACTIVE);
  assign err_passive_o = (state == NODE_PASSIVE);
  assign bus_off_o     = (state == NODE_BUSOFF);

  cfc_dom_run #(
    .FIRST_ACT (ACT_RUN),
    .FIRST_PAS (PAS_RUN),
    .REPEAT    (REP_RUN)
  ) u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (delim_i || cnt_clear_i || !en),
    .act_start_i (flag_start_i && !flag_passive_i),
    .pas_start_i (flag_start_i && flag_passive_i),
    .flag_done_i (flag_done_i),
    .tick_i      (bit_tick_i),
    .dom_i       (bus_dom_i),
    .pen_o       (run_pen)
  );

  cfc_pending #(
    .PW  (PW),
    .PEN (PENALTY)
  ) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (delim_i || cnt_clear_i),
    .en_i         (en),
    .err_det_i    (err_det_i),
    .err_kind_i   (err_kind_e'(err_kind_i)),
    .in_flag_i    (err_in_flag_i),
    .arb_stuff_i  (err_arb_stuff_i),
    .in_ifs_i     (err_in_ifs_i),
    .is_tx_i      (is_tx_i),
    .passive_i    (state == NODE_PASSIVE),
    .flag_start_i (flag_start_i),
    .flag_done_i  (flag_done_i),
    .tick_i       (bit_tick_i),
    .dom_i        (bus_dom_i),
    .run_pen_i    (run_pen),
    .pend_tec_o   (pend_tec),
    .pend_rec_o   (pend_rec),
    .ovl_req_o    (ovl_req_o)
  );

  cfc_counters #(
    .TEC_W     (TEC_W),
    .REC_W     (REC_W),
    .PW        (PW),
    .RX_RELOAD (RX_RELOAD),
    .PASS_TEC  (PASS_TEC)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cnt_clear_i),
    .commit_i   (delim_i),
    .pend_tec_i (pend_tec),
    .pend_rec_i (pend_rec),
    .tx_ok_i    (tx_ok_i),
    .rx_ok_i    (rx_ok_i),
    .tec_o      (tec_o),
    .rec_o      (rec_o),
    .rec_pass_o (rec_pass_o),
    .state_o    (state)
  );

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int TEC_W     = 8,
  parameter int REC_W     = 7,
  parameter int RX_RELOAD = 127
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clear_i,
  input logic             err_det_i,
  input logic [2:0]       err_kind_i,
  input logic             err_in_ifs_i,
  input logic             delim_i,
  input logic             tx_ok_i,
  input logic             rx_ok_i,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic             rec_pass_o,
  input logic             err_active_o,
  input logic             err_passive_o,
  input logic             bus_off_o,
  input logic             ovl_req_o
);

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(delim_i || tx_ok_i || rx_ok_i || cnt_clear_i)
    |=> $stable(tec_o) && $stable(rec_o) && $stable(rec_pass_o));

  p_tx_ok_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_off_o && tx_ok_i && !delim_i && !cnt_clear_i && tec_o != '0
    |=> tec_o == $past(tec_o) - 1'b1);

  p_rx_ok_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_off_o && rx_ok_i && !delim_i && !cnt_clear_i && rec_pass_o
    |=> rec_o == REC_W'(RX_RELOAD) && !rec_pass_o);

  p_one_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({err_active_o, err_passive_o, bus_off_o}));

  p_busoff_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_o && !cnt_clear_i
    |=> bus_off_o && $stable(tec_o) && $stable(rec_o));

  p_busoff_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_o |-> tec_o == '1);

  p_clear_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear_i |=> tec_o == '0 && rec_o == '0 && !bus_off_o);

  p_ifs_overload_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_det_i && err_in_ifs_i && err_kind_i == 3'd0 && !bus_off_o
    |=> ovl_req_o);

endmodule

bind can_fault_counters cfc_checker #(
  .TEC_W     (TEC_W),
  .REC_W     (REC_W),
  .RX_RELOAD (RX_RELOAD)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_clear_i   (cnt_clear_i),
  .err_det_i     (err_det_i),
  .err_kind_i    (err_kind_i),
  .err_in_ifs_i  (err_in_ifs_i),
  .delim_i       (delim_i),
  .tx_ok_i       (tx_ok_i),
  .rx_ok_i       (rx_ok_i),
  .tec_o         (tec_o),
  .rec_o         (rec_o),
  .rec_pass_o    (rec_pass_o),
  .err_active_o  (err_active_o),
  .err_passive_o (err_passive_o),
  .bus_off_o     (bus_off_o),
  .ovl_req_o     (ovl_req_o)
);

// File: tb/test_can_fault_counters.sv
`timescale 1ns/1ps
module test_can_fault_counters;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cnt_clear_i, is_tx_i, err_det_i;
  logic [2:0] err_kind_i;
  logic       err_in_flag_i, err_arb_stuff_i, err_in_ifs_i;
  logic       flag_start_i, flag_passive_i, flag_done_i;
  logic       bit_tick_i, bus_dom_i, delim_i, tx_ok_i, rx_ok_i;
  logic [7:0] tec_o;
  logic [6:0] rec_o;
  logic       rec_pass_o, err_active_o, err_passive_o, bus_off_o, ovl_req_o;

  can_fault_counters i_can_fault_counters (.*);

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    tec;
    int    rec;
    bit    pass;
    int    st;
    string tag;
  } exp_t;
  exp_t q[$];

  int m_tec = 0;
  int m_rec = 0;
  bit m_pass = 0;
  bit m_boff = 0;

  // monitor: pops expected items and compares with the outputs
  always @(negedge clk) begin
    exp_t it;
    int   st_act;
    while (q.size() > 0) begin
      it = q.pop_front();
      st_act = bus_off_o ? 2 : (err_passive_o ? 1 : (err_active_o ? 0 : 3));
      if (int'(err_active_o) + int'(err_passive_o) + int'(bus_off_o) != 1) st_act = 3;
      checks++;
      if (int'(tec_o) != it.tec || int'(rec_o) != it.rec ||
          rec_pass_o != it.pass || st_act != it.st) begin
        errors++;
        $display("FAIL %s: actual tec=%0d rec=%0d pass=%0d st=%0d expected tec=%0d rec=%0d pass=%0d st=%0d",
                 it.tag, tec_o, rec_o, rec_pass_o, st_act, it.tec, it.rec, it.pass, it.st);
      end
    end
  end

  task automatic expect_now(string tag);
    exp_t e;
    e.tec  = m_tec;
    e.rec  = m_rec;
    e.pass = m_pass;
    e.st   = m_boff ? 2 : ((m_tec >= 128 || m_pass) ? 1 : 0);  // R11
    e.tag  = tag;
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_commit(int dt, int dr);
    if (m_boff) return;
    m_tec += dt;
    if (m_tec > 255) begin m_tec = 255; m_boff = 1; end
    if (!m_pass) begin
      m_rec += dr;
      if (m_rec > 127) begin m_rec = 127; m_pass = 1; end
    end
  endtask

  task automatic pulse_err(int kind, bit inflag, bit arb, bit ifs);
    err_det_i = 1; err_kind_i = 3'(kind);
    err_in_flag_i = inflag; err_arb_stuff_i = arb; err_in_ifs_i = ifs;
    @(negedge clk);
    err_det_i = 0; err_in_flag_i = 0; err_arb_stuff_i = 0; err_in_ifs_i = 0;
  endtask

  task automatic ticks(int n, bit dom);
    for (int i = 0; i < n; i++) begin
      bit_tick_i = 1; bus_dom_i = dom;
      @(negedge clk);
      bit_tick_i = 0; bus_dom_i = 0;
    end
  endtask

  task automatic fstart(bit pas);
    flag_start_i = 1; flag_passive_i = pas; @(negedge clk);
    flag_start_i = 0; flag_passive_i = 0;
  endtask
  task automatic fdone();  flag_done_i = 1; @(negedge clk); flag_done_i = 0; endtask
  task automatic delim();  delim_i = 1;     @(negedge clk); delim_i = 0;     endtask
  task automatic txok();   tx_ok_i = 1;     @(negedge clk); tx_ok_i = 0;     endtask
  task automatic rxok();   rx_ok_i = 1;     @(negedge clk); rx_ok_i = 0;     endtask
  task automatic cclear(); cnt_clear_i = 1; @(negedge clk); cnt_clear_i = 0; endtask

  task automatic tx_frame(int kind);
    is_tx_i = 1;
    pulse_err(kind, 0, 0, 0);
    fstart(0); ticks(6, 1); ticks(1, 0); fdone(); delim();
  endtask

  initial begin
    rst_n = 0; cnt_clear_i = 0; is_tx_i = 0; err_det_i = 0; err_kind_i = 0;
    err_in_flag_i = 0; err_arb_stuff_i = 0; err_in_ifs_i = 0;
    flag_start_i = 0; flag_passive_i = 0; flag_done_i = 0;
    bit_tick_i = 0; bus_dom_i = 0; delim_i = 0; tx_ok_i = 0; rx_ok_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_now("R1 reset state");

    // R3 with R2: receiver CRC error, nothing visible before the delimiter
    is_tx_i = 0;
    pulse_err(2, 0, 0, 0);
    fstart(0); ticks(6, 1); ticks(1, 0); fdone(); ticks(1, 0);
    expect_now("R2 no change before delimiter");
    delim(); model_commit(0, 1);
    expect_now("R3 receiver error +1");

    // R6: dominant bit right after own flag
    pulse_err(3, 0, 0, 0);
    fstart(0); ticks(6, 1); fdone(); ticks(1, 1); ticks(1, 0); delim();
    model_commit(0, 9);
    expect_now("R6 dominant after flag +8");

    rxok(); m_rec -= 1;
    expect_now("R9 receive success -1");

    // R7 receiver: 14 dominant from active flag start
    pulse_err(2, 0, 0, 0);
    fstart(0); ticks(14, 1); ticks(1, 0); fdone(); delim();
    model_commit(0, 9);
    expect_now("R7 receiver 14-bit run +8");

    // R4 transmitter error +8
    tx_frame(2); model_commit(8, 0);
    expect_now("R4 transmitter error +8");

    // R4 arbitration stuff exception
    is_tx_i = 1;
    pulse_err(1, 0, 1, 0); delim();
    expect_now("R4 arbitration stuff exception");

    // R5 bit error during own flag, transmitter
    pulse_err(0, 1, 0, 0); delim(); model_commit(8, 0);
    expect_now("R5 bit error in flag +8");

    // R7 transmitter: 14 then 8 more dominant
    pulse_err(2, 0, 0, 0);
    fstart(0); ticks(14, 1); ticks(8, 1); ticks(1, 0); fdone(); delim();
    model_commit(24, 0);
    expect_now("R7 run 14 plus 8 penalties");

    txok(); m_tec -= 1;
    expect_now("R8 transmit success -1");

    // drive into error-passive
    while (m_tec < 128) begin tx_frame(2); model_commit(8, 0); end
    expect_now("R11 passive by transmit count");

    // R4 acknowledgement exception while passive
    is_tx_i = 1;
    pulse_err(4, 0, 0, 0);
    fstart(1); ticks(6, 0); fdone(); delim();
    expect_now("R4 ack error while passive ignored");

    pulse_err(4, 0, 0, 0);
    fstart(1); ticks(1, 1); ticks(5, 0); fdone(); delim();
    model_commit(8, 0);
    expect_now("R4 ack error with dominant in passive flag");

    // R7 passive flag: 8 dominant after it ends
    pulse_err(2, 0, 0, 0);
    fstart(1); ticks(6, 0); fdone(); ticks(8, 1); ticks(1, 0); delim();
    model_commit(16, 0);
    expect_now("R7 passive flag 8-bit run");

    // R12 bus-off
    while (m_tec + 8 < 256) begin tx_frame(2); model_commit(8, 0); end
    expect_now("R12 just below bus-off");
    tx_frame(2); model_commit(8, 0);
    expect_now("R12 enter bus-off, count 255");
    txok(); rxok(); tx_frame(2);
    expect_now("R12 events ignored in bus-off");
    cclear(); m_tec = 0; m_rec = 0; m_pass = 0; m_boff = 0;
    expect_now("R12 clear strobe");

    // R8 / R9 floors
    txok(); rxok();
    expect_now("R8 R9 floor at zero");

    // R10 receive saturation, R5 receiver side
    is_tx_i = 0;
    for (int i = 0; i < 15; i++) begin
      pulse_err(0, 1, 0, 0); delim(); model_commit(0, 8);
    end
    expect_now("R5 receiver bit error in flag");
    pulse_err(0, 1, 0, 0); delim(); model_commit(0, 8);
    expect_now("R10 receive saturates, passive flag");
    pulse_err(2, 0, 0, 0); delim(); model_commit(0, 1);
    expect_now("R10 held while passive flag set");
    rxok(); m_pass = 0; m_rec = 127;
    expect_now("R9 passive reload 127");
    rxok(); m_rec -= 1;
    expect_now("R9 decrement after reload");

    // R13 intermission bit error
    pulse_err(0, 0, 0, 1);
    chk_bit("R13 overload request pulse", ovl_req_o, 1'b1);
    @(negedge clk);
    chk_bit("R13 overload request one cycle", ovl_req_o, 1'b0);
    delim();
    expect_now("R13 no count change");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule